// File: doc/BRIEF.md
# Decode-Stage Issue Interlock for a Mixed-Latency Pipeline

This block sits in the decode stage of an in-order pipeline. Behind decode are an integer ALU, a load path and three floating-point units with different execute depths. Each cycle it looks at the decoded instruction and raises one stall signal whenever that instruction cannot yet leave decode. The instruction fields it reads are the unit class, the destination register, up to two source registers and a store flag. While the stall is high, the surrounding pipeline freezes the fetch and decode registers and sends a bubble into execute.

The block keeps three kinds of state.

- **Per-register countdown.** Each architectural register has a countdown of the cycles left until its pending result can be forwarded. A value of zero means the result is ready.
- **Divider countdown.** A separate countdown tracks the divider, which is not pipelined.
- **MEM reservation map.** A one-bit-per-cycle map records the future cycles in which the single MEM stage is already claimed.

Earlier instructions claim their MEM cycle first. A younger instruction that would reach MEM in a claimed cycle is given the next free cycle instead, which models it waiting in its last execute stage. Its result countdown grows by the same number of cycles.

Top module: `issue_interlock`

## Requirements
- R1: After reset all countdowns, the divider state and the MEM map are clear, so the first instruction issues without a stall.
- R2: A divide issued while an earlier divide is still within its 30 cycles stalls. A divide right behind a divide stalls exactly 29 cycles. A divide does not block instructions of other unit classes.
- R3: Unit class codes on `decUnit` are 0 integer (1 stage), 1 FP add (5 stages), 2 FP multiply (10 stages), 3 FP divide (30 stages) and 4 load. An ALU instruction reading the result of the instruction just before it stalls one cycle fewer than the producer's stage count: 0, 4, 9 or 29 cycles.
- R4: An instruction that uses a load result in the very next instruction stalls exactly one cycle.
- R5: With `decIsStore` high, source B is store data. Store data is allowed one cycle less than an ALU operand, so a store right behind an FP add stalls 3 cycles on its data. The store's source A (address) keeps the full ALU rule, giving 4 cycles after an FP add.
- R6: An instruction whose destination still has a nonzero countdown stalls in decode until that countdown reaches zero, so a write behind a multiply to the same register stalls 9 cycles.
- R7: An instruction that would reach MEM in a cycle already claimed by an older one takes the next free MEM cycle. Its result becomes available that many cycles later. An FP add issued 5 cycles after an FP multiply makes its dependant stall 5 cycles instead of 4.
- R8: Independent integer, add and multiply instructions can issue on consecutive cycles without a stall.
- R9: The stall output is low whenever `decValid` is low. Countdowns keep advancing during such idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| decValid | input | 1 | Decode holds a valid instruction |
| decUnit | input | 3 | Unit class code (see R3) |
| decDstWr | input | 1 | Instruction writes a destination register |
| decDst | input | 5 | Destination register number |
| decSrcAUse | input | 1 | Source A is read |
| decSrcA | input | 5 | Source A register number |
| decSrcBUse | input | 1 | Source B is read |
| decSrcB | input | 5 | Source B register number (store data when storing) |
| decIsStore | input | 1 | Instruction is a store |
| stall | output | 1 | Instruction must stay in decode this cycle |

## Verification
The MEM arbitration and the RAW countdown meet on the same instruction. An FP add issued five cycles after an FP multiply aims for the same MEM cycle. In that one issue cycle it is pushed to a later MEM slot, and its result countdown is loaded with the longer value. A directed sequence provokes this: a multiply, four independent integer instructions, the add, and then a reader of the add's result. The check passes only if the reader stalls five cycles rather than four. Random streams over a small register set make divider-busy, WAW and RAW conditions overlap in one decode cycle, and a cycle-level bench model judges each cycle's stall.

// File: rtl/issue_lock_pkg.sv
package issue_lock_pkg;
  parameter int NUM_REGS = 32;
  parameter int REG_W    = $clog2(NUM_REGS);
  parameter int SLOTS    = 32;
  parameter int SLOT_W   = $clog2(SLOTS);
  parameter int CNT_W    = SLOT_W;

  typedef enum logic [2:0] {
    UNIT_INT  = 3'd0,
    UNIT_ADD  = 3'd1,
    UNIT_MUL  = 3'd2,
    UNIT_DIV  = 3'd3,
    UNIT_LOAD = 3'd4
  } unit_e;

  typedef struct packed {
    logic              issue;
    logic              writeDst;
    logic              startDiv;
    logic [SLOT_W-1:0] slot;
    logic [CNT_W-1:0]  dstVal;
  } strobe_t;
endpackage

// File: rtl/il_datapath.sv
module il_datapath
  import issue_lock_pkg::*;
#(
  parameter int LAT_DIV = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [REG_W-1:0]  decDst,
  input  logic [REG_W-1:0]  decSrcA,
  input  logic [REG_W-1:0]  decSrcB,
  input  logic [SLOT_W-1:0] minSlot,
  output logic [CNT_W-1:0]  cntA,
  output logic [CNT_W-1:0]  cntB,
  output logic [CNT_W-1:0]  cntDst,
  output logic              divBusy,
  output logic [SLOT_W-1:0] freeSlot,
  output logic              slotFound
);
  localparam int DIV_W = $clog2(LAT_DIV + 1);

  logic [NUM_REGS-1:0][CNT_W-1:0] cntVec;
  logic [DIV_W-1:0]               divCnt;
  logic [SLOTS-1:0]               memRes;

  // One result countdown per architectural register
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN)                                       cntVec[r] <= '0;
      else if (stb.writeDst && decDst == REG_W'(r))    cntVec[r] <= stb.dstVal;
      else if (cntVec[r] != '0)                        cntVec[r] <= cntVec[r] - 1'b1;
    end
  end

  assign cntA   = cntVec[decSrcA];
  assign cntB   = cntVec[decSrcB];
  assign cntDst = cntVec[decDst];

  always_ff @(posedge clk) begin
    if (!rstN)             divCnt <= '0;
    else if (stb.startDiv) divCnt <= DIV_W'(LAT_DIV - 1);
    else if (divCnt != '0) divCnt <= divCnt - 1'b1;
  end
  assign divBusy = (divCnt != '0);

  // Bit k: MEM is claimed k cycles from now
  always_ff @(posedge clk) begin
    if (!rstN) memRes <= '0;
    else       memRes <= (memRes >> 1) |
                         (stb.issue ? (SLOTS'(1) << (stb.slot - 1'b1)) : '0);
  end

  // Lowest free MEM cycle at or beyond the requested one
  always_comb begin
    freeSlot  = '0;
    slotFound = 1'b0;
    for (int k = SLOTS - 1; k >= 1; k--) begin
      if (k >= int'(minSlot) && !memRes[k]) begin
        slotFound = 1'b1;
        freeSlot  = SLOT_W'(k);
      end
    end
  end

  assert_div_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.startDiv |-> !divBusy);
  assert_slot_claimed_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.issue |=> memRes[$past(stb.slot) - 1'b1]);
  assert_count_loaded_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.writeDst |=> cntVec[$past(decDst)] == $past(stb.dstVal));
endmodule

// File: rtl/il_control.sv
module il_control
  import issue_lock_pkg::*;
#(
  parameter int LAT_ADD = 5,
  parameter int LAT_MUL = 10,
  parameter int LAT_DIV = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              decValid,
  input  logic [2:0]        decUnit,
  input  logic              decDstWr,
  input  logic              decIsStore,
  input  logic              decSrcAUse,
  input  logic              decSrcBUse,
  input  logic [CNT_W-1:0]  cntA,
  input  logic [CNT_W-1:0]  cntB,
  input  logic [CNT_W-1:0]  cntDst,
  input  logic              divBusy,
  input  logic [SLOT_W-1:0] freeSlot,
  input  logic              slotFound,
  output logic [SLOT_W-1:0] minSlot,
  output logic              stall,
  output strobe_t           stb
);
  logic rawA, rawB, wawHaz, divHaz, memHaz, isLoad, writes;

  // MEM is reached one cycle after the last execute stage
  always_comb begin
    case (unit_e'(decUnit))
      UNIT_ADD: minSlot = SLOT_W'(LAT_ADD + 1);
      UNIT_MUL: minSlot = SLOT_W'(LAT_MUL + 1);
      UNIT_DIV: minSlot = SLOT_W'(LAT_DIV + 1);
      default:  minSlot = SLOT_W'(2);
    endcase
  end

  assign isLoad = (unit_e'(decUnit) == UNIT_LOAD);
  assign writes = decDstWr && !decIsStore;
  assign rawA   = decSrcAUse && (cntA != '0);
  assign rawB   = decSrcBUse && (decIsStore ? (cntB > CNT_W'(1)) : (cntB != '0));
  assign wawHaz = writes && (cntDst != '0);
  assign divHaz = (unit_e'(decUnit) == UNIT_DIV) && divBusy;
  assign memHaz = !slotFound;

  assign stall = decValid && (rawA || rawB || wawHaz || divHaz || memHaz);

  always_comb begin
    stb.issue    = decValid && !stall;
    stb.writeDst = stb.issue && writes;
    stb.startDiv = stb.issue && (unit_e'(decUnit) == UNIT_DIV);
    stb.slot     = freeSlot;
    stb.dstVal   = CNT_W'(freeSlot - SLOT_W'(2) + SLOT_W'(isLoad));
  end

  assert_div_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && decUnit == 3'd3 && divBusy) |-> stall);
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !decValid |-> !stall);
endmodule

// File: rtl/issue_interlock.sv
module issue_interlock
  import issue_lock_pkg::*;
#(
  parameter int LAT_ADD = 5,
  parameter int LAT_MUL = 10,
  parameter int LAT_DIV = 30
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             decValid,
  input  logic [2:0]       decUnit,
  input  logic             decDstWr,
  input  logic [REG_W-1:0] decDst,
  input  logic             decSrcAUse,
  input  logic [REG_W-1:0] decSrcA,
  input  logic             decSrcBUse,
  input  logic [REG_W-1:0] decSrcB,
  input  logic             decIsStore,
  output logic             stall
);
  strobe_t           stb;
  logic [CNT_W-1:0]  cntA, cntB, cntDst;
  logic              divBusy, slotFound;
  logic [SLOT_W-1:0] freeSlot, minSlot;

  il_control #(.LAT_ADD(LAT_ADD), .LAT_MUL(LAT_MUL), .LAT_DIV(LAT_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .decValid(decValid), .decUnit(decUnit),
    .decDstWr(decDstWr), .decIsStore(decIsStore), .decSrcAUse(decSrcAUse),
    .decSrcBUse(decSrcBUse), .cntA(cntA), .cntB(cntB), .cntDst(cntDst),
    .divBusy(divBusy), .freeSlot(freeSlot), .slotFound(slotFound),
    .minSlot(minSlot), .stall(stall), .stb(stb)
  );

  il_datapath #(.LAT_DIV(LAT_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .decDst(decDst), .decSrcA(decSrcA),
    .decSrcB(decSrcB), .minSlot(minSlot), .cntA(cntA), .cntB(cntB),
    .cntDst(cntDst), .divBusy(divBusy), .freeSlot(freeSlot),
    .slotFound(slotFound)
  );
endmodule

// File: tb/tb_issue_interlock.sv
module tb_issue_interlock;
  logic clk = 1'b0, rstN = 1'b0;
  logic decValid = 0, decDstWr = 0, decSrcAUse = 0, decSrcBUse = 0, decIsStore = 0;
  logic [2:0] decUnit = 0;
  logic [4:0] decDst = 0, decSrcA = 0, decSrcB = 0;
  logic stall;

  int checks = 0, fails = 0;
  bit finished = 0;

  int mCnt[32];
  int mDiv;
  bit mMem[32];

  always #4 clk = ~clk;

  issue_interlock dut (.*);

  function automatic int reqSlot(int u);
    case (u) 1: return 6; 2: return 11; 3: return 31; default: return 2; endcase
  endfunction

  function automatic int firstFree(int d);
    for (int k = d; k < 32; k++) if (!mMem[k]) return k;
    return -1;
  endfunction

  function automatic bit expStall();
    bit s = 0;
    if (!decValid) return 0;
    if (decSrcAUse && mCnt[decSrcA] != 0) s = 1;
    if (decSrcBUse && (decIsStore ? mCnt[decSrcB] > 1 : mCnt[decSrcB] != 0)) s = 1;
    if (decDstWr && !decIsStore && mCnt[decDst] != 0) s = 1;
    if (decUnit == 3 && mDiv != 0) s = 1;
    if (firstFree(reqSlot(decUnit)) < 0) s = 1;
    return s;
  endfunction

  task automatic modelStep(bit iss);
    int s = firstFree(reqSlot(decUnit));
    for (int r = 0; r < 32; r++) if (mCnt[r] > 0) mCnt[r]--;
    if (mDiv > 0) mDiv--;
    for (int k = 0; k < 31; k++) mMem[k] = mMem[k+1];
    mMem[31] = 0;
    if (iss) begin
      mMem[s-1] = 1;
      if (decDstWr && !decIsStore) mCnt[decDst] = s - 2 + (decUnit == 4 ? 1 : 0);
      if (decUnit == 3) mDiv = 29;
    end
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      decValid = 0;
      #1 check(stall == 1'b0, "R9", stall, 0);
      @(posedge clk);
      modelStep(0);
    end
  endtask

  task automatic instr(int u, bit dw, int d, bit au, int a, bit bu, int b, bit st,
                       output int stalls);
    bit done = 0;
    stalls = 0;
    while (!done) begin
      bit e;
      @(negedge clk);
      decValid = 1; decUnit = 3'(u); decDstWr = dw; decDst = 5'(d);
      decSrcAUse = au; decSrcA = 5'(a); decSrcBUse = bu; decSrcB = 5'(b);
      decIsStore = st;
      #1 e = expStall();
      check(stall == e, "model", stall, e);
      @(posedge clk);
      modelStep(!e);
      if (!e) done = 1; else stalls++;
    end
  endtask

  task automatic expectStalls(string req, int got, int want);
    check(got == want, req, got, want);
  endtask

  initial begin
    #(8 * 190000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    int seed;
    for (int r = 0; r < 32; r++) mCnt[r] = 0;
    for (int k = 0; k < 32; k++) mMem[k] = 0;
    mDiv = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;

    // R1 reset state
    instr(1, 1, 1, 0, 0, 0, 0, 0, n); expectStalls("R1", n, 0);
    // R3 add -> dependent add
    instr(1, 1, 2, 1, 1, 1, 1, 0, n); expectStalls("R3 add", n, 4);
    idle(40);
    instr(2, 1, 3, 0, 0, 0, 0, 0, n);
    instr(2, 1, 4, 1, 3, 0, 0, 0, n); expectStalls("R3 mul", n, 9);
    idle(40);
    instr(0, 1, 1, 0, 0, 0, 0, 0, n);
    instr(0, 1, 2, 1, 1, 0, 0, 0, n); expectStalls("R3 int", n, 0);
    // R4 load-use
    instr(4, 1, 5, 0, 0, 0, 0, 0, n);
    instr(0, 1, 6, 1, 5, 0, 0, 0, n); expectStalls("R4", n, 1);
    idle(40);
    // R5 store data vs address
    instr(1, 1, 7, 0, 0, 0, 0, 0, n);
    instr(0, 0, 0, 0, 0, 1, 7, 1, n); expectStalls("R5 data", n, 3);
    idle(40);
    instr(1, 1, 8, 0, 0, 0, 0, 0, n);
    instr(0, 0, 0, 1, 8, 0, 0, 1, n); expectStalls("R5 addr", n, 4);
    idle(40);
    // R2 divider
    instr(3, 1, 9, 0, 0, 0, 0, 0, n);
    instr(3, 1, 10, 0, 0, 0, 0, 0, n); expectStalls("R2 div-div", n, 29);
    instr(1, 1, 12, 0, 0, 0, 0, 0, n); expectStalls("R2 other unit", n, 0);
    idle(40);
    // R6 WAW
    instr(2, 1, 13, 0, 0, 0, 0, 0, n);
    instr(0, 1, 13, 0, 0, 0, 0, 0, n); expectStalls("R6", n, 9);
    idle(40);
    // R7 MEM collision, R8 back-to-back
    instr(2, 1, 14, 0, 0, 0, 0, 0, n); expectStalls("R8 mul", n, 0);
    for (int i = 0; i < 4; i++) begin
      instr(0, 1, 15 + i, 0, 0, 0, 0, 0, n); expectStalls("R8 int", n, 0);
    end
    instr(1, 1, 19, 0, 0, 0, 0, 0, n); expectStalls("R8 add", n, 0);
    instr(0, 1, 20, 1, 19, 0, 0, 0, n); expectStalls("R7", n, 5);
    idle(40);

    // constrained random
    seed = 32'h5eed;
    void'($urandom(seed));
    for (int i = 0; i < 1200; i++) begin
      int u = $urandom_range(0, 4);
      bit st = ($urandom_range(0, 99) < 15);
      if (st) u = 0;
      instr(u, !st, $urandom_range(1, 7), $urandom_range(0, 1), $urandom_range(1, 7),
            $urandom_range(0, 1), $urandom_range(1, 7), st, n);
      if ($urandom_range(0, 9) == 0) idle($urandom_range(1, 4));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule